// File: doc/BRIEF.md
# Vector Operand Fetch with Swizzle and Relative Addressing

This block fetches one four-lane source operand for a vector shader ALU. A request names a register index, chooses one of two register files (the float uniform file or the temporary/input file), and says which source slot of the instruction the operand fills and which opcode form the instruction uses. From these fields the block forms a read address. One of three index registers (two address registers or the loop counter) may be added to the index as a signed relative offset. The sum wraps modulo the depth of the chosen file.

The relative offset is applied to only one source slot per instruction. Which slot that is depends on whether the opcode is an ordinary two-source form or a multiply-add form, and on whether the operands are swapped. The word that comes back from the register file is then reordered lane by lane under an 8-bit selector. The block can also negate the whole vector by flipping the sign bit of every lane. The result leaves with a one-cycle valid strobe.

The read port is a plain synchronous request/response. The address is registered one cycle after the request. The file answers in the following cycle, and the operand is registered one cycle after that. A new request is accepted every cycle.

Top module: `vecOperandFetch`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rdEn` and `outValid` are low.
- R2: A request sampled at a clock edge raises `rdEn` with its address after that edge. The file returns `rdData` one cycle later. `outValid` rises one cycle after that, three edges after the request.
- R3: `rdUniform` equals the request's `reqUniform`. A uniform operand is addressed modulo `UNIF_DEPTH` and any other operand modulo `TEMP_DEPTH`.
- R4: The relative offset is added only when `reqSlot` equals the slot that takes it. That slot is 1 for the plain form (`reqMad`=0, `reqInv`=0), 2 for the swapped plain form (`reqMad`=0, `reqInv`=1), 2 for multiply-add (`reqMad`=1, `reqInv`=0), and 3 for swapped multiply-add (`reqMad`=1, `reqInv`=1). Slot 0 never takes it.
- R5: `reqAddrSel` picks the offset. 0 means none, 1 means `addrReg0`, 2 means `addrReg1`, and 3 means `loopReg`.
- R6: The offset is a two's-complement value. `rdAddr` is (`reqIndex` + offset) reduced into 0 to depth-1 of the chosen file, so negative sums wrap to the top of the file.
- R7: Lanes are packed with x in the lowest `LANE_W` bits and w in the highest. Output lane x takes input lane `reqSwizzle[7:6]`, y takes `[5:4]`, z takes `[3:2]` and w takes `[1:0]`, where 0 means x and 3 means w.
- R8: The selector 0x1B with negate clear returns the read word unchanged.
- R9: With `reqNegate` set, the MSB of every lane of the swizzled result is inverted, so a zero lane becomes negative zero.
- R10: Requests on consecutive cycles each produce their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Fetch request this cycle |
| reqSlot | input | 2 | Source slot number (1 to 3) |
| reqMad | input | 1 | Instruction is a multiply-add form |
| reqInv | input | 1 | Instruction uses the swapped-operand form |
| reqUniform | input | 1 | Operand lives in the uniform file |
| reqIndex | input | ADDR_W | Register index |
| reqAddrSel | input | 2 | Relative offset source |
| reqSwizzle | input | 8 | Lane selector |
| reqNegate | input | 1 | Negate the operand |
| addrReg0 | input | OFF_W | First address register (signed) |
| addrReg1 | input | OFF_W | Second address register (signed) |
| loopReg | input | OFF_W | Loop counter register (signed) |
| rdEn | output | 1 | Register file read strobe |
| rdUniform | output | 1 | Read targets the uniform file |
| rdAddr | output | ADDR_W | Read address |
| rdData | input | 4*LANE_W | Read data, valid the cycle after `rdEn` |
| outValid | output | 1 | Operand valid |
| outVec | output | 4*LANE_W | Swizzled, optionally negated operand |

## Verification
The hardest case to reach from the ports is a relative offset that pushes the address below zero or past the end of the uniform file while the slot and opcode form line up. Random stimulus seldom gets this, because it needs the right slot, the right form, a non-zero selector and a large enough offset all together. Directed requests therefore set up each slot/form pairing and both wrap directions with hand-picked register values. Random traffic, issued back-to-back with register values that change every cycle, then checks that each request's address and result stay tied to the values present in its own cycle.

// File: rtl/opFetchPkg.sv
package opFetchPkg;

  // Per-stage strobes from control to datapath
  typedef struct packed {
    logic issue;    // request accepted, register address
    logic advance;  // read in flight, file answers next cycle
    logic capture;  // read data present, register result
  } stageStrobes_t;

  localparam int SEL_W = 8;
  localparam int LANES = 4;

  // Slot that takes the relative offset for a given opcode form
  function automatic logic [1:0] relSlotOf(input logic isMad, input logic isInv);
    if (isMad) return isInv ? 2'd3 : 2'd2;
    return isInv ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/opFetchAddrCalc.sv
module opFetchAddrCalc
  import opFetchPkg::*;
#(
  parameter int TEMP_DEPTH = 32,
  parameter int UNIF_DEPTH = 96,
  parameter int OFF_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic [1:0]        slot,
  input  logic              isMad,
  input  logic              isInv,
  input  logic              isUniform,
  input  logic [ADDR_W-1:0] index,
  input  logic [1:0]        addrSel,
  input  logic [OFF_W-1:0]  addrReg0,
  input  logic [OFF_W-1:0]  addrReg1,
  input  logic [OFF_W-1:0]  loopReg,
  output logic [ADDR_W-1:0] addr
);
  localparam int SUM_W = ((ADDR_W > OFF_W) ? ADDR_W : OFF_W) + 2;
  localparam logic signed [SUM_W-1:0] TEMP_D = SUM_W'(TEMP_DEPTH);
  localparam logic signed [SUM_W-1:0] UNIF_D = SUM_W'(UNIF_DEPTH);

  logic [OFF_W-1:0]        offPick;
  logic                    useRel;
  logic signed [SUM_W-1:0] offExt;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] remTemp;
  logic signed [SUM_W-1:0] remUnif;

  always_comb begin
    unique case (addrSel)
      2'd1:    offPick = addrReg0;
      2'd2:    offPick = addrReg1;
      2'd3:    offPick = loopReg;
      default: offPick = '0;
    endcase
  end

  assign useRel = (addrSel != 2'd0) && (slot == relSlotOf(isMad, isInv));
  assign offExt = useRel ? $signed({{(SUM_W-OFF_W){offPick[OFF_W-1]}}, offPick}) : '0;
  assign sum    = $signed({{(SUM_W-ADDR_W){1'b0}}, index}) + offExt;

  always_comb begin
    remTemp = sum % TEMP_D;
    if (remTemp < 0) remTemp = remTemp + TEMP_D;
    remUnif = sum % UNIF_D;
    if (remUnif < 0) remUnif = remUnif + UNIF_D;
  end

  assign addr = isUniform ? ADDR_W'(remUnif) : ADDR_W'(remTemp);

endmodule

// File: rtl/opFetchLaneSwizzle.sv
module opFetchLaneSwizzle
  import opFetchPkg::*;
#(
  parameter int LANE_W = 24
) (
  input  logic [LANES*LANE_W-1:0] vecIn,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    neg,
  output logic [LANES*LANE_W-1:0] vecOut
);
  logic [LANE_W-1:0] laneIn [LANES];
  logic [LANE_W-1:0] signFlip;

  assign signFlip = {neg, {(LANE_W-1){1'b0}}};

  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign laneIn[i] = vecIn[i*LANE_W +: LANE_W];
  end

  // Output lane k reads the selector pair starting at the top for lane x
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [1:0] pick;
    assign pick = sel[SEL_W-1-2*k -: 2];
    assign vecOut[k*LANE_W +: LANE_W] = laneIn[pick] ^ signFlip;
  end

endmodule

// File: rtl/opFetchCtrl.sv
module opFetchCtrl
  import opFetchPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output stageStrobes_t strb,
  output logic          rdEn,
  output logic          outValid
);
  logic dataPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEn        <= 1'b0;
      dataPending <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      rdEn        <= reqValid;
      dataPending <= rdEn;
      outValid    <= dataPending;
    end
  end

  assign strb.issue   = reqValid;
  assign strb.advance = rdEn;
  assign strb.capture = dataPending;

  // R2
  req_to_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rdEn);

  // R2
  out_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(reqValid, 3));

endmodule

// File: rtl/opFetchDatapath.sv
module opFetchDatapath
  import opFetchPkg::*;
#(
  parameter int LANE_W = 24,
  parameter int TEMP_DEPTH = 32,
  parameter int UNIF_DEPTH = 96,
  parameter int OFF_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  stageStrobes_t           strb,
  input  logic [1:0]              reqSlot,
  input  logic                    reqMad,
  input  logic                    reqInv,
  input  logic                    reqUniform,
  input  logic [ADDR_W-1:0]       reqIndex,
  input  logic [1:0]              reqAddrSel,
  input  logic [SEL_W-1:0]        reqSwizzle,
  input  logic                    reqNegate,
  input  logic [OFF_W-1:0]        addrReg0,
  input  logic [OFF_W-1:0]        addrReg1,
  input  logic [OFF_W-1:0]        loopReg,
  output logic                    rdUniform,
  output logic [ADDR_W-1:0]       rdAddr,
  input  logic [LANES*LANE_W-1:0] rdData,
  output logic [LANES*LANE_W-1:0] outVec
);
  localparam int VEC_W = LANES * LANE_W;
  localparam logic [VEC_W-1:0] SIGN_MASK = {LANES{1'b1, {(LANE_W-1){1'b0}}}};

  logic [ADDR_W-1:0] addrNext;
  logic [SEL_W-1:0]  swzIssued, swzPending;
  logic              negIssued, negPending;
  logic [VEC_W-1:0]  shuffled;

  opFetchAddrCalc #(
    .TEMP_DEPTH(TEMP_DEPTH), .UNIF_DEPTH(UNIF_DEPTH), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) u_addrCalc (
    .slot(reqSlot), .isMad(reqMad), .isInv(reqInv), .isUniform(reqUniform),
    .index(reqIndex), .addrSel(reqAddrSel), .addrReg0(addrReg0),
    .addrReg1(addrReg1), .loopReg(loopReg), .addr(addrNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr    <= '0;
      rdUniform <= 1'b0;
    end else if (strb.issue) begin
      rdAddr    <= addrNext;
      rdUniform <= reqUniform;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.issue) begin
      swzIssued <= reqSwizzle;
      negIssued <= reqNegate;
    end
    if (strb.advance) begin
      swzPending <= swzIssued;
      negPending <= negIssued;
    end
    if (strb.capture) outVec <= shuffled;
  end

  opFetchLaneSwizzle #(.LANE_W(LANE_W)) u_laneSwizzle (
    .vecIn(rdData), .sel(swzPending), .neg(negPending), .vecOut(shuffled)
  );

  // R6
  temp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && !rdUniform |-> rdAddr < ADDR_W'(TEMP_DEPTH));

  // R6
  unif_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && rdUniform |-> rdAddr < ADDR_W'(UNIF_DEPTH));

  // R5
  no_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue && reqAddrSel == 2'd0 && reqIndex < ADDR_W'(TEMP_DEPTH)
      |=> rdAddr == $past(reqIndex));

  // R4
  wrong_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue && !reqMad && !reqInv && reqSlot == 2'd2 && reqIndex < ADDR_W'(TEMP_DEPTH)
      |=> rdAddr == $past(reqIndex));

  // R8
  identity_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && swzPending == 8'h1B && !negPending |=> outVec == $past(rdData));

  // R9
  negate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && swzPending == 8'h1B && negPending
      |=> (outVec ^ $past(rdData)) == SIGN_MASK);

endmodule

// File: rtl/vecOperandFetch.sv
module vecOperandFetch
  import opFetchPkg::*;
#(
  parameter int LANE_W = 24,
  parameter int TEMP_DEPTH = 32,
  parameter int UNIF_DEPTH = 96,
  parameter int OFF_W = 8,
  localparam int ADDR_W = $clog2((TEMP_DEPTH > UNIF_DEPTH) ? TEMP_DEPTH : UNIF_DEPTH),
  localparam int VEC_W = 4 * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqSlot,
  input  logic              reqMad,
  input  logic              reqInv,
  input  logic              reqUniform,
  input  logic [ADDR_W-1:0] reqIndex,
  input  logic [1:0]        reqAddrSel,
  input  logic [7:0]        reqSwizzle,
  input  logic              reqNegate,
  input  logic [OFF_W-1:0]  addrReg0,
  input  logic [OFF_W-1:0]  addrReg1,
  input  logic [OFF_W-1:0]  loopReg,
  output logic              rdEn,
  output logic              rdUniform,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [VEC_W-1:0]  rdData,
  output logic              outValid,
  output logic [VEC_W-1:0]  outVec
);
  stageStrobes_t strb;

  opFetchCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .strb(strb),
    .rdEn(rdEn), .outValid(outValid)
  );

  opFetchDatapath #(
    .LANE_W(LANE_W), .TEMP_DEPTH(TEMP_DEPTH), .UNIF_DEPTH(UNIF_DEPTH),
    .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqSlot(reqSlot), .reqMad(reqMad), .reqInv(reqInv), .reqUniform(reqUniform),
    .reqIndex(reqIndex), .reqAddrSel(reqAddrSel), .reqSwizzle(reqSwizzle),
    .reqNegate(reqNegate), .addrReg0(addrReg0), .addrReg1(addrReg1), .loopReg(loopReg),
    .rdUniform(rdUniform), .rdAddr(rdAddr), .rdData(rdData), .outVec(outVec)
  );

endmodule

// File: tb/test_vecOperandFetch.sv
module test_vecOperandFetch;
  localparam int CLK_PERIOD = 10;
  localparam int LANE_W = 24;
  localparam int TEMP_DEPTH = 32;
  localparam int UNIF_DEPTH = 96;
  localparam int OFF_W = 8;
  localparam int ADDR_W = 7;
  localparam int VEC_W = 4 * LANE_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqMad = 1'b0, reqInv = 1'b0, reqUniform = 1'b0, reqNegate = 1'b0;
  logic [1:0] reqSlot = '0, reqAddrSel = '0;
  logic [ADDR_W-1:0] reqIndex = '0;
  logic [7:0] reqSwizzle = '0;
  logic [OFF_W-1:0] addrReg0 = '0, addrReg1 = '0, loopReg = '0;
  logic rdEn, rdUniform, outValid;
  logic [ADDR_W-1:0] rdAddr;
  logic [VEC_W-1:0] rdData = '0;
  logic [VEC_W-1:0] outVec;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // history of requests: index 1 = one cycle ago, 3 = three cycles ago
  logic             hV    [1:3];
  logic [ADDR_W-1:0] hAddr [1:3];
  logic             hUnif [1:3];
  logic [VEC_W-1:0] hVec  [1:3];
  string            hTag  [1:3];

  always #(CLK_PERIOD/2) clk = ~clk;

  vecOperandFetch i_vecOperandFetch (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSlot(reqSlot), .reqMad(reqMad),
    .reqInv(reqInv), .reqUniform(reqUniform), .reqIndex(reqIndex), .reqAddrSel(reqAddrSel),
    .reqSwizzle(reqSwizzle), .reqNegate(reqNegate), .addrReg0(addrReg0),
    .addrReg1(addrReg1), .loopReg(loopReg), .rdEn(rdEn), .rdUniform(rdUniform),
    .rdAddr(rdAddr), .rdData(rdData), .outValid(outValid), .outVec(outVec)
  );

  function automatic logic [LANE_W-1:0] laneVal(input logic unif, input int addr, input int lane);
    if (!unif && addr == 0) return '0;
    return LANE_W'((unif ? 32'h10_0000 : 0) + addr * 256 + lane * 16 + 5);
  endfunction

  function automatic logic [VEC_W-1:0] fileWord(input logic unif, input int addr);
    logic [VEC_W-1:0] w;
    for (int l = 0; l < 4; l++) w[l*LANE_W +: LANE_W] = laneVal(unif, addr, l);
    return w;
  endfunction

  // register file model: answers the cycle after rdEn
  always @(posedge clk) if (rdEn) rdData <= fileWord(rdUniform, int'(rdAddr));

  function automatic int expAddr(input logic [1:0] slot, input logic mad, input logic inv,
                                 input logic unif, input int idx, input logic [1:0] asel,
                                 input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] lp);
    int off, take, depth, s, r;
    case (asel)
      2'd1: off = int'($signed(r0));
      2'd2: off = int'($signed(r1));
      2'd3: off = int'($signed(lp));
      default: off = 0;
    endcase
    take = mad ? (inv ? 3 : 2) : (inv ? 2 : 1);
    if (int'(slot) != take) off = 0;
    depth = unif ? UNIF_DEPTH : TEMP_DEPTH;
    s = idx + off;
    r = s % depth;
    if (r < 0) r += depth;
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] expVec(input logic [VEC_W-1:0] w, input logic [7:0] swz,
                                              input logic neg);
    logic [VEC_W-1:0] o;
    for (int k = 0; k < 4; k++) begin
      int src;
      src = int'(swz[7-2*k -: 2]);
      o[k*LANE_W +: LANE_W] = w[src*LANE_W +: LANE_W];
      if (neg) o[k*LANE_W + LANE_W-1] = ~o[k*LANE_W + LANE_W-1];
    end
    return o;
  endfunction

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  // one cycle: check outputs of earlier requests, then drive the next one
  task automatic step(input logic v, input logic [1:0] slot, input logic mad, input logic inv,
                      input logic unif, input int idx, input logic [1:0] asel,
                      input logic [7:0] swz, input logic neg, input logic [7:0] r0,
                      input logic [7:0] r1, input logic [7:0] lp, input string tag);
    int a;
    checkBit({"R2 rdEn ", hTag[1]}, rdEn, hV[1]);
    if (hV[1]) begin
      checks++;
      if (rdAddr !== hAddr[1] || rdUniform !== hUnif[1]) begin
        failures++;
        $display("FAIL %s rdAddr act=%0d/%0b exp=%0d/%0b", hTag[1], rdAddr, rdUniform,
                 hAddr[1], hUnif[1]);
      end
    end
    checkBit({"R2 outValid ", hTag[3]}, outValid, hV[3]);
    if (hV[3]) begin
      checks++;
      if (outVec !== hVec[3]) begin
        failures++;
        $display("FAIL %s outVec act=%h exp=%h", hTag[3], outVec, hVec[3]);
      end
    end
    for (int i = 3; i > 1; i--) begin
      hV[i] = hV[i-1]; hAddr[i] = hAddr[i-1]; hUnif[i] = hUnif[i-1];
      hVec[i] = hVec[i-1]; hTag[i] = hTag[i-1];
    end
    a = expAddr(slot, mad, inv, unif, idx, asel, r0, r1, lp);
    hV[1] = v; hAddr[1] = ADDR_W'(a); hUnif[1] = unif;
    hVec[1] = expVec(fileWord(unif, a), swz, neg); hTag[1] = tag;
    reqValid = v; reqSlot = slot; reqMad = mad; reqInv = inv; reqUniform = unif;
    reqIndex = ADDR_W'(idx); reqAddrSel = asel; reqSwizzle = swz; reqNegate = neg;
    addrReg0 = r0; addrReg1 = r1; loopReg = lp;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 0, 2'd0, 8'h1B, 1'b0, 8'h0, 8'h0, 8'h0, "idle");
  endtask

  initial begin
    int seedVal;
    seedVal = int'($urandom(32'd2024));
    for (int i = 1; i <= 3; i++) begin
      hV[i] = 1'b0; hAddr[i] = '0; hUnif[i] = 1'b0; hVec[i] = '0; hTag[i] = "idle";
    end
    repeat (3) @(negedge clk);
    checkBit("R1 rdEn in reset", rdEn, 1'b0);
    checkBit("R1 outValid in reset", outValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkBit("R1 rdEn after reset", rdEn, 1'b0);
    checkBit("R1 outValid after reset", outValid, 1'b0);

    // identity, negate, swizzles
    step(1, 2'd1, 0, 0, 0, 5, 2'd0, 8'h1B, 0, 8'h0, 8'h0, 8'h0, "R8 identity");
    step(1, 2'd1, 0, 0, 0, 0, 2'd0, 8'h1B, 1, 8'h0, 8'h0, 8'h0, "R9 negate zero");
    step(1, 2'd2, 0, 0, 1, 7, 2'd0, 8'h1B, 1, 8'h0, 8'h0, 8'h0, "R9 negate uniform");
    step(1, 2'd1, 0, 0, 0, 9, 2'd0, 8'h00, 0, 8'h0, 8'h0, 8'h0, "R7 broadcast x");
    step(1, 2'd1, 0, 0, 0, 9, 2'd0, 8'hE4, 0, 8'h0, 8'h0, 8'h0, "R7 reverse");
    step(1, 2'd1, 0, 0, 1, 9, 2'd0, 8'h9C, 1, 8'h0, 8'h0, 8'h0, "R7 R9 mixed");
    // file select
    step(1, 2'd1, 0, 0, 1, 20, 2'd0, 8'h1B, 0, 8'h0, 8'h0, 8'h0, "R3 uniform file");
    step(1, 2'd1, 0, 0, 0, 20, 2'd0, 8'h1B, 0, 8'h0, 8'h0, 8'h0, "R3 temp file");
    // slot choice per opcode form, offset +3 from addrReg0
    step(1, 2'd1, 0, 0, 0, 4, 2'd1, 8'h1B, 0, 8'd3, 8'd0, 8'd0, "R4 plain slot1 takes");
    step(1, 2'd2, 0, 0, 0, 4, 2'd1, 8'h1B, 0, 8'd3, 8'd0, 8'd0, "R4 plain slot2 skips");
    step(1, 2'd2, 0, 1, 0, 4, 2'd1, 8'h1B, 0, 8'd3, 8'd0, 8'd0, "R4 swapped slot2 takes");
    step(1, 2'd1, 0, 1, 0, 4, 2'd1, 8'h1B, 0, 8'd3, 8'd0, 8'd0, "R4 swapped slot1 skips");
    step(1, 2'd2, 1, 0, 0, 4, 2'd1, 8'h1B, 0, 8'd3, 8'd0, 8'd0, "R4 mad slot2 takes");
    step(1, 2'd3, 1, 0, 0, 4, 2'd1, 8'h1B, 0, 8'd3, 8'd0, 8'd0, "R4 mad slot3 skips");
    step(1, 2'd3, 1, 1, 0, 4, 2'd1, 8'h1B, 0, 8'd3, 8'd0, 8'd0, "R4 madswap slot3 takes");
    step(1, 2'd0, 0, 0, 0, 4, 2'd1, 8'h1B, 0, 8'd3, 8'd0, 8'd0, "R4 slot0 skips");
    // offset source
    step(1, 2'd1, 0, 0, 0, 1, 2'd0, 8'h1B, 0, 8'd2, 8'd6, 8'd11, "R5 sel none");
    step(1, 2'd1, 0, 0, 0, 1, 2'd1, 8'h1B, 0, 8'd2, 8'd6, 8'd11, "R5 sel reg0");
    step(1, 2'd1, 0, 0, 0, 1, 2'd2, 8'h1B, 0, 8'd2, 8'd6, 8'd11, "R5 sel reg1");
    step(1, 2'd1, 0, 0, 0, 1, 2'd3, 8'h1B, 0, 8'd2, 8'd6, 8'd11, "R5 sel loop");
    // wrap: 2-5 -> 29 temp; 90+10 -> 4 uniform; 95+127 -> 30 uniform
    step(1, 2'd1, 0, 0, 0, 2, 2'd1, 8'h1B, 0, 8'hFB, 8'd0, 8'd0, "R6 negative wrap");
    step(1, 2'd1, 0, 0, 1, 90, 2'd2, 8'h1B, 0, 8'd0, 8'd10, 8'd0, "R6 uniform top wrap");
    step(1, 2'd1, 0, 0, 1, 95, 2'd3, 8'h1B, 0, 8'd0, 8'd0, 8'h7F, "R6 max offset");
    step(1, 2'd1, 0, 0, 0, 0, 2'd3, 8'h1B, 0, 8'd0, 8'd0, 8'h80, "R6 min offset");
    step(1, 2'd1, 0, 0, 0, 100, 2'd0, 8'h1B, 0, 8'd0, 8'd0, 8'd0, "R6 index past temp");
    idle(); idle(); idle();

    // random back-to-back traffic
    for (int n = 0; n < 3000; n++) begin
      logic v;
      v = ($urandom_range(0, 9) != 0);
      step(v, 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom),
           int'($urandom_range(0, 127)), 2'($urandom_range(0, 3)), 8'($urandom),
           1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R10 random");
    end
    idle(); idle(); idle(); idle();

    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog act=running exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule